// File: doc/BRIEF.md
# Linked-Load / Store-Conditional Reservation Controller

This block sits in front of a word-addressed memory and makes linked-load/store-conditional pairs atomic for a set of requesting sources. Each request carries one of four commands, a source identifier, a word address and write data. The controller handles one request at a time. It answers every request with exactly one response, tagged with the same source identifier.

The controller holds one reservation per source, and a reservation covers a whole cache line of `LINE_WORDS` words. A linked load records a reservation. A store-conditional writes only while the source's reservation on that line is still standing, and the first such store to be processed removes every reservation on the line. A plain write also removes every reservation on its line. Because tracking is per line, two accesses to different words of the same line can break each other's reservations.

The memory is a simple single-port word array inside the block, with a registered read.

Top module: `llsc_resv_ctrl`

## Requirements
- R1: The command encoding is 0 = READ, 1 = WRITE, 2 = LINKED_LOAD and 3 = STORE_CONDITIONAL. A READ returns the stored word at the address. A WRITE stores `req_wdata` and returns response data 0.
- R2: A LINKED_LOAD from source S to address X records a reservation for S on the line of X and returns the stored word at X.
- R3: A new LINKED_LOAD from a source replaces that source's earlier reservation, so a later STORE_CONDITIONAL to the old line fails.
- R4: A STORE_CONDITIONAL from S succeeds when S holds a reservation on the line of its address. On success it writes the word, returns 0, and cancels every reservation on that line.
- R5: A STORE_CONDITIONAL without a matching reservation leaves memory unchanged and returns 1.
- R6: When several sources hold reservations on one line, the first STORE_CONDITIONAL processed succeeds and the others then fail.
- R7: A WRITE cancels every reservation held on its line.
- R8: Matching is by line, where line = address / `LINE_WORDS`. An access to any word of a line counts as an access to the whole line.
- R9: `req_ready` is low while a response is pending. The response appears on the cycle after acceptance, carries the request's source, and stays stable until `rsp_ready` is high.
- R10: A READ neither creates nor cancels any reservation.
- R11: After reset, no reservation exists and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cmd | input | 2 | Command code (R1) |
| req_src | input | $clog2(NUM_SRC) | Requesting source identifier |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data for WRITE and STORE_CONDITIONAL |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_src | output | $clog2(NUM_SRC) | Source identifier of the response |
| rsp_data | output | DATA_W | Read word, or 0/1 result code |

## Verification
The bench uses the defaults: 8 sources, 16-word lines and a 256-word memory, which gives 16 lines. It aims the random traffic at only three of those lines. With eight sources crowding a few lines, the random mix keeps producing races between store-conditionals, cancellations by writes to neighbouring words, and reservation replacements. Directed sequences pin down winner order, read transparency and response hold under back-pressure.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_LL    = 2'd2,
        CMD_SC    = 2'd3
    } cmd_e;

    // result codes returned by a store-conditional: nonzero means retry
    localparam logic SC_WIN  = 1'b0;
    localparam logic SC_LOSE = 1'b1;
endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
    parameter int NUM_SRC = 8,
    parameter int LINE_W  = 4,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  look_src,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              set_en,
    input  logic [SRC_W-1:0]  set_src,
    input  logic [LINE_W-1:0] set_line,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] clr_line
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } entry_t;

    entry_t [NUM_SRC-1:0] ent_d, ent_q;
    logic   [NUM_SRC-1:0] clr_match;

    // one comparator per source entry
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
        assign clr_match[g] = ent_q[g].vld && (ent_q[g].line == clr_line);
    end

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_en && clr_match[i]) begin
                ent_d[i].vld = 1'b0;
            end
            if (set_en && (set_src == SRC_W'(i))) begin
                ent_d[i].vld  = 1'b1;
                ent_d[i].line = set_line;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign look_hit = ent_q[look_src].vld && (ent_q[look_src].line == look_line);

    function automatic logic line_held(input logic [LINE_W-1:0] l);
        logic any;
        any = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ent_q[i].vld && ent_q[i].line == l) any = 1'b1;
        end
        return any;
    endfunction

    a_r2_set_records: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (ent_q[$past(set_src)].vld && ent_q[$past(set_src)].line == $past(set_line)));

    a_r7_clear_sweeps_line: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !line_held($past(clr_line)));
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        if (re) begin
            rdata_q <= store[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl
    import llsc_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int LINE_WORDS = 16,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int OFF_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    localparam int LINE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [SRC_W-1:0]  rsp_src,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic             busy;
        logic [SRC_W-1:0] src;
        logic             from_mem;
        logic             code;
    } state_t;

    state_t            st_d, st_q;
    cmd_e              cmd;
    logic              fire;
    logic              hit;
    logic              mem_we;
    logic              set_en;
    logic              clr_en;
    logic [LINE_W-1:0] req_line;
    logic [DATA_W-1:0] mem_rdata;

    assign cmd       = cmd_e'(req_cmd);
    assign req_line  = req_addr[ADDR_W-1:OFF_W];
    assign req_ready = !st_q.busy;
    assign fire      = req_valid && req_ready;

    always_comb begin
        st_d   = st_q;
        set_en = fire && (cmd == CMD_LL);
        clr_en = fire && ((cmd == CMD_WRITE) || ((cmd == CMD_SC) && hit));
        mem_we = clr_en;
        if (fire) begin
            st_d.busy     = 1'b1;
            st_d.src      = req_src;
            st_d.from_mem = (cmd == CMD_READ) || (cmd == CMD_LL);
            st_d.code     = ((cmd == CMD_SC) && !hit) ? SC_LOSE : SC_WIN;
        end else if (st_q.busy && rsp_ready) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    llsc_resv_table #(
        .NUM_SRC (NUM_SRC),
        .LINE_W  (LINE_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_src  (req_src),
        .look_line (req_line),
        .look_hit  (hit),
        .set_en    (set_en),
        .set_src   (req_src),
        .set_line  (req_line),
        .clr_en    (clr_en),
        .clr_line  (req_line)
    );

    llsc_word_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) mem_i (
        .clk   (clk),
        .re    (fire),
        .we    (mem_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (mem_rdata)
    );

    assign rsp_valid = st_q.busy;
    assign rsp_src   = st_q.src;
    assign rsp_data  = st_q.from_mem ? mem_rdata : DATA_W'(st_q.code);

    a_r9_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_valid && rsp_src == $past(req_src)));

    a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_src)));

    a_r5_sc_code_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd == CMD_SC) |=> (rsp_data[DATA_W-1:1] == '0));
endmodule

// File: tb/llsc_resv_ctrl_tb_top.sv
module llsc_resv_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int LW   = 16;
    localparam int AW   = 8;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_cmd = 2'd0;
    logic [2:0]    req_src = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [2:0]    rsp_src;
    logic [DW-1:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [DW-1:0] m_mem [1 << AW];
    bit            m_vld [NSRC];
    logic [3:0]    m_line[NSRC];

    always #2 clk = ~clk;

    llsc_resv_ctrl #(.NUM_SRC(NSRC), .LINE_WORDS(LW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_src(rsp_src), .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic void clear_line(input logic [3:0] l);
        for (int i = 0; i < NSRC; i++) if (m_vld[i] && m_line[i] == l) m_vld[i] = 1'b0;
    endfunction

    // reference behaviour from the requirements; updates the model state
    function automatic logic [DW-1:0] model(input logic [1:0] c, input logic [2:0] s,
                                            input logic [AW-1:0] a, input logic [DW-1:0] w);
        logic [3:0] l;
        logic [DW-1:0] r;
        l = a[7:4];
        r = '0;
        case (c)
            2'd0: r = m_mem[a];
            2'd1: begin m_mem[a] = w; clear_line(l); r = '0; end
            2'd2: begin r = m_mem[a]; m_vld[s] = 1'b1; m_line[s] = l; end
            default: begin
                if (m_vld[s] && m_line[s] == l) begin
                    m_mem[a] = w; clear_line(l); r = '0;
                end else begin
                    r = 1;
                end
            end
        endcase
        return r;
    endfunction

    task automatic do_op(input logic [1:0] c, input logic [2:0] s, input logic [AW-1:0] a,
                         input logic [DW-1:0] w, output logic [DW-1:0] got, output logic [2:0] gsrc,
                         output logic gv);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_src = s; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        got = rsp_data; gsrc = rsp_src; gv = rsp_valid;
    endtask

    task automatic op_chk(input string rq, input logic [1:0] c, input logic [2:0] s,
                          input logic [AW-1:0] a, input logic [DW-1:0] w);
        logic [DW-1:0] exp, got;
        logic [2:0] gs;
        logic gv;
        exp = model(c, s, a, w);
        do_op(c, s, a, w, got, gs, gv);
        chk({rq, " data"}, got, exp);
        chk("R9 src/valid", {28'd0, gv, gs}, {28'd0, 1'b1, s});
    endtask

    initial begin
        logic [DW-1:0] got, held;
        logic [2:0] gs;
        logic gv;
        void'($urandom(32'd1234));
        for (int i = 0; i < NSRC; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R11 req_ready after reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;

        // fill memory with known words (R1 write path)
        for (int a = 0; a < (1 << AW); a++) begin
            void'(model(2'd1, 3'd0, AW'(a), DW'(a * 7 + 3)));
            do_op(2'd1, 3'd0, AW'(a), DW'(a * 7 + 3), got, gs, gv);
        end
        op_chk("R11 no reservation after reset", 2'd3, 3'd3, 8'h05, 32'hAAAA);
        op_chk("R1 read word", 2'd0, 3'd1, 8'h05, 32'h0);
        op_chk("R1 write ack", 2'd1, 3'd1, 8'h06, 32'h1234);
        op_chk("R1 read back", 2'd0, 3'd2, 8'h06, 32'h0);

        // R2 / R4: LL then SC succeeds; second SC fails (R5)
        op_chk("R2 LL returns word", 2'd2, 3'd2, 8'h10, 32'h0);
        op_chk("R4 SC success code 0", 2'd3, 3'd2, 8'h10, 32'hBEEF);
        op_chk("R4 SC wrote word", 2'd0, 3'd0, 8'h10, 32'h0);
        op_chk("R5 repeat SC fails", 2'd3, 3'd2, 8'h10, 32'hDEAD);
        op_chk("R5 failed SC no write", 2'd0, 3'd0, 8'h10, 32'h0);

        // R6: two contenders, first SC wins
        op_chk("R6 LL src4", 2'd2, 3'd4, 8'h20, 32'h0);
        op_chk("R6 LL src5", 2'd2, 3'd5, 8'h21, 32'h0);
        op_chk("R6 first SC wins", 2'd3, 3'd5, 8'h21, 32'h55);
        op_chk("R6 second SC loses", 2'd3, 3'd4, 8'h20, 32'h44);

        // R3: replacement of reservation
        op_chk("R3 LL line3", 2'd2, 3'd6, 8'h30, 32'h0);
        op_chk("R3 LL line4", 2'd2, 3'd6, 8'h40, 32'h0);
        op_chk("R3 SC old line fails", 2'd3, 3'd6, 8'h30, 32'h1);
        op_chk("R3 SC new line wins", 2'd3, 3'd6, 8'h4F, 32'h2);

        // R7 / R8: write to a neighbouring word breaks reservation
        op_chk("R8 LL word 0x52", 2'd2, 3'd1, 8'h52, 32'h0);
        op_chk("R7 write word 0x5E", 2'd1, 3'd7, 8'h5E, 32'h77);
        op_chk("R8 SC after neighbour write fails", 2'd3, 3'd1, 8'h52, 32'h9);
        op_chk("R8 LL other line", 2'd2, 3'd1, 8'h62, 32'h0);
        op_chk("R8 write different line", 2'd1, 3'd7, 8'h72, 32'h8);
        op_chk("R8 SC other word same line ok", 2'd3, 3'd1, 8'h6A, 32'h9);

        // R10: reads leave reservations intact
        op_chk("R10 LL", 2'd2, 3'd0, 8'h80, 32'h0);
        op_chk("R10 read same word", 2'd0, 3'd3, 8'h80, 32'h0);
        op_chk("R10 read own", 2'd0, 3'd0, 8'h81, 32'h0);
        op_chk("R10 SC still wins", 2'd3, 3'd0, 8'h80, 32'h3);

        // R9: back-pressure holds the response
        void'(model(2'd0, 3'd2, 8'h90, 32'h0));
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_cmd = 2'd0; req_src = 3'd2; req_addr = 8'h90;
        @(negedge clk);
        req_valid = 1'b0;
        held = rsp_data;
        chk("R9 read under backpressure", held, m_mem[8'h90]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 held data", rsp_data, held);
            chk("R9 held valid, not ready", {30'd0, rsp_valid, req_ready}, {30'd0, 2'b10});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9 released", {31'd0, rsp_valid}, 32'd0);

        // random traffic concentrated on three lines
        for (int n = 0; n < 1500; n++) begin
            logic [1:0] c;
            c = 2'($urandom % 4);
            op_chk("R4 random mix", c, 3'($urandom % NSRC),
                   {4'($urandom % 3), 4'($urandom % 16)}, $urandom);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule